// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes the byte stream of received packets and places it into a ring of buffer descriptors kept in a small on-chip memory next to it. Each descriptor has a status word and a data buffer. The engine takes hold of a descriptor only while that descriptor's empty flag is set. It fills the buffer up to a programmable maximum length and, when a packet is longer, continues in the following descriptor. When it closes a buffer it writes back the status and the byte count. After a descriptor marked as the end of the ring, the next one used is the ring base.

The descriptor memory and the data buffers sit outside the block. The engine reads the status of one descriptor through a combinational read port, and writes status, length and data bytes through synchronous write ports. Two sticky events report results: buffer closed and packet dropped for lack of buffers. A mask gates the events into one interrupt line.

Top module: `rxbd_ring_engine`

## Requirements
- R1: A descriptor receives data only if its status reads empty (bit 10 = 1) at the moment it is claimed. Every status write-back clears the empty bit and leaves the ring-end bit (bit 9) and the interrupt bit (bit 8) as they were read. The engine writes to no other descriptor.
- R2: When a buffer holds maxLen bytes and another byte of the same packet arrives, the buffer is closed with length maxLen and last bit (bit 6) = 0. That byte goes to offset 0 of the next descriptor. maxLen is a multiple of 4 and at least 4.
- R3: At end of packet the current buffer closes with the last bit set and a length equal to the bytes written into it. The end-of-packet error inputs are copied into the status: bit 3 non-octet, bit 2 bit-stuff abort, bit 1 CRC error, bit 0 overrun. A CRC error does not discard the bytes already stored.
- R4: The first bit (bit 7) is set only in the descriptor holding the packet's first byte. Only that descriptor carries the data PID in bits 5:4 (00 DATA0, 01 DATA1). Every other descriptor has 00 there.
- R5: After a descriptor with the ring-end bit set, the next descriptor used is baseIdx. Otherwise it is the following index, modulo DESC_CNT.
- R6: If a packet's first byte arrives while the current descriptor is not empty, nothing is written, the whole packet is dropped, the busy event (events bit 1) is set, and the ring position does not change.
- R7: If a packet needs another buffer and the next descriptor is not empty, the current buffer closes with the last bit set and no error flags. The busy event is set, the rest of the packet is dropped, and the ring position moves to that next descriptor.
- R8: The buffer event (events bit 0) is set when a buffer closes, but only if that descriptor's interrupt bit is set.
- R9: Events stay set until a 1 is written to the matching evClr bit. irq is high exactly when some event is set and its evMask bit is 1.
- R10: After reset both events are clear, no write strobe is active, and the ring position (shown on descRdIdx while idle) equals baseIdx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| baseIdx | input | IDX_W | Index of the ring's first descriptor |
| maxLen | input | LEN_W | Maximum bytes per buffer (multiple of 4, at least 4) |
| rxValid | input | 1 | Received byte valid |
| rxSop | input | 1 | Marks the first byte of a packet |
| rxByte | input | 8 | Received byte |
| rxPid | input | 2 | Data PID, sampled with the first byte |
| rxEop | input | 1 | End of packet, one cycle after the last byte |
| rxCrcErr | input | 1 | CRC failure, qualified by rxEop |
| rxNonOct | input | 1 | Bit count not a multiple of 8, qualified by rxEop |
| rxOverrun | input | 1 | Receive overrun, qualified by rxEop |
| rxStuffErr | input | 1 | Bit-stuff violation, qualified by rxEop |
| descRdIdx | output | IDX_W | Descriptor status read index |
| descRdStat | input | 11 | Status of descriptor descRdIdx, combinational |
| descWrEn | output | 1 | Status and length write strobe |
| descWrIdx | output | IDX_W | Descriptor being closed |
| descWrStat | output | 11 | Status written on close |
| descWrLen | output | LEN_W | Data length written on close |
| dataWrEn | output | 1 | Data byte write strobe |
| dataWrIdx | output | IDX_W | Descriptor whose buffer is written |
| dataWrOffset | output | LEN_W | Byte offset in that buffer |
| dataWrByte | output | 8 | Data byte |
| evClr | input | 2 | Write-1-to-clear for the events |
| evMask | input | 2 | Interrupt enables for the events |
| events | output | 2 | Sticky events: bit 0 buffer closed, bit 1 busy |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong ring pointer or a stale copy of the ring-end bit shows up in the first status write after the fault, as a write to the wrong descriptor index. It is also visible on descRdIdx one cycle after the packet ends. A byte counter that is off by one shows on the same close, either as a wrong length or as the last bit on the wrong descriptor. It also moves every later data offset. Faults in claiming a descriptor or in detecting busy show within the packet that triggers them, as a change to a descriptor that should be untouched or as a busy event that is missing. The bench therefore compares every descriptor and buffer against its own model after every packet.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  // Descriptor status word, empty flag in the top bit.
  typedef struct packed {
    logic       empty;
    logic       ringEnd;
    logic       intEn;
    logic       first;
    logic       last;
    logic [1:0] pid;
    logic       nonOct;
    logic       abort;
    logic       crcErr;
    logic       overrun;
  } bdStat_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic startPkt;
    logic takeDesc;
    logic putByte;
    logic close;
    logic closeLast;
    logic useEndFlags;
    logic setBsy;
  } ctlStrb_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FILL,
    S_FULL,
    S_DROP
  } rxState_t;

endpackage

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl
  import rxbd_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rxSop,
  input  logic             rxEop,
  input  logic             rdEmpty,
  input  logic [LEN_W-1:0] lenCnt,
  input  logic [LEN_W-1:0] maxLen,
  output ctlStrb_t         strb,
  output logic             lookNext
);

  rxState_t state, nxtState;
  logic     lenFull;

  // The byte written this cycle fills the buffer.
  assign lenFull  = ({1'b0, lenCnt} + (LEN_W+1)'(1)) == {1'b0, maxLen};
  assign lookNext = (state == S_FULL);

  always_comb begin
    strb     = '0;
    nxtState = state;
    case (state)
      S_IDLE: begin
        if (rxValid && rxSop) begin
          if (rdEmpty) begin
            strb.startPkt = 1'b1;
            strb.takeDesc = 1'b1;
            nxtState      = S_FILL;
          end else begin
            strb.setBsy = 1'b1;
            nxtState    = S_DROP;
          end
        end
      end
      S_FILL: begin
        if (rxEop) begin
          strb.close       = 1'b1;
          strb.closeLast   = 1'b1;
          strb.useEndFlags = 1'b1;
          nxtState         = S_IDLE;
        end else if (rxValid) begin
          strb.putByte = 1'b1;
          if (lenFull) nxtState = S_FULL;
        end
      end
      S_FULL: begin
        if (rxEop) begin
          strb.close       = 1'b1;
          strb.closeLast   = 1'b1;
          strb.useEndFlags = 1'b1;
          nxtState         = S_IDLE;
        end else if (rxValid) begin
          strb.close = 1'b1;
          if (rdEmpty) begin
            strb.takeDesc = 1'b1;
            nxtState      = S_FILL;
          end else begin
            strb.closeLast = 1'b1;
            strb.setBsy    = 1'b1;
            nxtState       = S_DROP;
          end
        end
      end
      S_DROP: begin
        if (rxEop) nxtState = S_IDLE;
      end
      default: nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxtState;
  end

endmodule

// File: rtl/rxbd_path.sv
module rxbd_path
  import rxbd_pkg::*;
#(
  parameter int DESC_CNT = 8,
  parameter int LEN_W    = 8,
  localparam int IDX_W   = $clog2(DESC_CNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic             lookNext,
  input  logic [IDX_W-1:0] baseIdx,
  input  logic [7:0]       rxByte,
  input  logic [1:0]       rxPid,
  input  logic [3:0]       endFlags,
  input  bdStat_t          rdStat,
  output logic [IDX_W-1:0] descRdIdx,
  output logic [LEN_W-1:0] lenCnt,
  output logic             descWrEn,
  output logic [IDX_W-1:0] descWrIdx,
  output bdStat_t          wrStat,
  output logic [LEN_W-1:0] descWrLen,
  output logic             dataWrEn,
  output logic [IDX_W-1:0] dataWrIdx,
  output logic [LEN_W-1:0] dataWrOffset,
  output logic [7:0]       dataWrByte,
  output logic             rxbSet
);

  logic [IDX_W-1:0] curIdx, nextIdx;
  logic             curRingEnd, curIntEn, firstFlag;
  logic [1:0]       pidReg;

  always_comb begin
    if (curRingEnd)                         nextIdx = baseIdx;
    else if (curIdx == IDX_W'(DESC_CNT-1))  nextIdx = '0;
    else                                    nextIdx = curIdx + IDX_W'(1);
  end

  assign descRdIdx = lookNext ? nextIdx : curIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx     <= baseIdx;
      lenCnt     <= '0;
      curRingEnd <= 1'b0;
      curIntEn   <= 1'b0;
      firstFlag  <= 1'b0;
      pidReg     <= 2'b00;
    end else begin
      if (strb.startPkt) pidReg <= rxPid;
      if (strb.takeDesc) begin
        curIdx     <= descRdIdx;
        curRingEnd <= rdStat.ringEnd;
        curIntEn   <= rdStat.intEn;
        lenCnt     <= LEN_W'(1);
        firstFlag  <= strb.startPkt;
      end else begin
        if (strb.putByte) lenCnt <= lenCnt + LEN_W'(1);
        if (strb.close)   curIdx <= nextIdx;
      end
    end
  end

  always_comb begin
    wrStat         = '0;
    wrStat.empty   = 1'b0;
    wrStat.ringEnd = curRingEnd;
    wrStat.intEn   = curIntEn;
    wrStat.first   = firstFlag;
    wrStat.last    = strb.closeLast;
    wrStat.pid     = firstFlag ? pidReg : 2'b00;
    if (strb.useEndFlags) begin
      wrStat.nonOct  = endFlags[3];
      wrStat.abort   = endFlags[2];
      wrStat.crcErr  = endFlags[1];
      wrStat.overrun = endFlags[0];
    end
  end

  assign descWrEn     = strb.close;
  assign descWrIdx    = curIdx;
  assign descWrLen    = lenCnt;
  assign dataWrEn     = strb.takeDesc | strb.putByte;
  assign dataWrIdx    = strb.takeDesc ? descRdIdx : curIdx;
  assign dataWrOffset = strb.takeDesc ? '0 : lenCnt;
  assign dataWrByte   = rxByte;
  assign rxbSet       = strb.close & curIntEn;

endmodule

// File: rtl/rxbd_events.sv
module rxbd_events #(
  parameter int EV_CNT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EV_CNT-1:0] evSet,
  input  logic [EV_CNT-1:0] evClr,
  input  logic [EV_CNT-1:0] evMask,
  output logic [EV_CNT-1:0] events,
  output logic              irq
);

  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (!rstN) events <= '0;
    else       events <= (events & ~evClr) | evSet;
  end

  assign irq = |(events & evMask);

endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine
  import rxbd_pkg::*;
#(
  parameter int DESC_CNT = 8,
  parameter int LEN_W    = 8,
  localparam int IDX_W   = $clog2(DESC_CNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] baseIdx,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             rxValid,
  input  logic             rxSop,
  input  logic [7:0]       rxByte,
  input  logic [1:0]       rxPid,
  input  logic             rxEop,
  input  logic             rxCrcErr,
  input  logic             rxNonOct,
  input  logic             rxOverrun,
  input  logic             rxStuffErr,
  output logic [IDX_W-1:0] descRdIdx,
  input  logic [10:0]      descRdStat,
  output logic             descWrEn,
  output logic [IDX_W-1:0] descWrIdx,
  output logic [10:0]      descWrStat,
  output logic [LEN_W-1:0] descWrLen,
  output logic             dataWrEn,
  output logic [IDX_W-1:0] dataWrIdx,
  output logic [LEN_W-1:0] dataWrOffset,
  output logic [7:0]       dataWrByte,
  input  logic [1:0]       evClr,
  input  logic [1:0]       evMask,
  output logic [1:0]       events,
  output logic             irq
);

  ctlStrb_t         strb;
  logic             lookNext;
  logic [LEN_W-1:0] lenCnt;
  bdStat_t          rdStat, wrStat;
  logic             rxbSet;

  assign rdStat     = bdStat_t'(descRdStat);
  assign descWrStat = wrStat;

  rxbd_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxValid  (rxValid),
    .rxSop    (rxSop),
    .rxEop    (rxEop),
    .rdEmpty  (rdStat.empty),
    .lenCnt   (lenCnt),
    .maxLen   (maxLen),
    .strb     (strb),
    .lookNext (lookNext)
  );

  rxbd_path #(.DESC_CNT(DESC_CNT), .LEN_W(LEN_W)) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .lookNext     (lookNext),
    .baseIdx      (baseIdx),
    .rxByte       (rxByte),
    .rxPid        (rxPid),
    .endFlags     ({rxNonOct, rxStuffErr, rxCrcErr, rxOverrun}),
    .rdStat       (rdStat),
    .descRdIdx    (descRdIdx),
    .lenCnt       (lenCnt),
    .descWrEn     (descWrEn),
    .descWrIdx    (descWrIdx),
    .wrStat       (wrStat),
    .descWrLen    (descWrLen),
    .dataWrEn     (dataWrEn),
    .dataWrIdx    (dataWrIdx),
    .dataWrOffset (dataWrOffset),
    .dataWrByte   (dataWrByte),
    .rxbSet       (rxbSet)
  );

  rxbd_events #(.EV_CNT(2)) u_events (
    .clk    (clk),
    .rstN   (rstN),
    .evSet  ({strb.setBsy, rxbSet}),
    .evClr  (evClr),
    .evMask (evMask),
    .events (events),
    .irq    (irq)
  );

endmodule

// File: rtl/rxbd_chk.sv
module rxbd_chk #(
  parameter int DESC_CNT = 8,
  parameter int LEN_W    = 8,
  localparam int IDX_W   = $clog2(DESC_CNT)
) (
  input logic             clk,
  input logic             rstN,
  input logic [LEN_W-1:0] maxLen,
  input logic             rxValid,
  input logic [IDX_W-1:0] descRdIdx,
  input logic [10:0]      descRdStat,
  input logic             descWrEn,
  input logic [10:0]      descWrStat,
  input logic [LEN_W-1:0] descWrLen,
  input logic             dataWrEn,
  input logic [IDX_W-1:0] dataWrIdx,
  input logic [LEN_W-1:0] dataWrOffset,
  input logic [1:0]       evClr,
  input logic [1:0]       events
);

  // R1
  claim_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrEn && dataWrOffset == '0) |-> (descRdStat[10] && descRdIdx == dataWrIdx));

  // R2
  offset_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWrEn |-> (dataWrOffset < maxLen));

  // R2
  chained_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (descWrEn && !descWrStat[6]) |-> (descWrLen == maxLen));

  // R3
  close_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    descWrEn |-> (descWrLen != '0 && descWrLen <= maxLen));

  // R4
  pid_first_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (descWrEn && !descWrStat[7]) |-> (descWrStat[5:4] == 2'b00));

  // R8
  rxb_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(events[0]) |-> $past(descWrEn && descWrStat[8]));

  // R6
  bsy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(events[1]) |-> $past(rxValid));

  // R9
  rxb_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (events[0] && !evClr[0]) |=> events[0]);

  // R9
  bsy_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (events[1] && !evClr[1]) |=> events[1]);

endmodule

bind rxbd_ring_engine rxbd_chk #(.DESC_CNT(DESC_CNT), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .maxLen       (maxLen),
  .rxValid      (rxValid),
  .descRdIdx    (descRdIdx),
  .descRdStat   (descRdStat),
  .descWrEn     (descWrEn),
  .descWrStat   (descWrStat),
  .descWrLen    (descWrLen),
  .dataWrEn     (dataWrEn),
  .dataWrIdx    (dataWrIdx),
  .dataWrOffset (dataWrOffset),
  .evClr        (evClr),
  .events       (events)
);

// File: tb/sim_rxbd_ring_engine.sv
module sim_rxbd_ring_engine;

  localparam int DESC = 8;
  localparam int LW   = 8;
  localparam int IW   = 3;
  localparam int BUF  = 16;
  localparam int BASE = 2;
  localparam int LAST = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [IW-1:0] baseIdx = IW'(BASE);
  logic [LW-1:0] maxLen = 8'd8;
  logic          rxValid = 0, rxSop = 0, rxEop = 0;
  logic [7:0]    rxByte = 0;
  logic [1:0]    rxPid = 0;
  logic          rxCrcErr = 0, rxNonOct = 0, rxOverrun = 0, rxStuffErr = 0;
  logic [IW-1:0] descRdIdx, descWrIdx, dataWrIdx;
  logic [10:0]   descRdStat, descWrStat;
  logic          descWrEn, dataWrEn, irq;
  logic [LW-1:0] descWrLen, dataWrOffset;
  logic [7:0]    dataWrByte;
  logic [1:0]    evClr = 0, evMask = 0, events;

  logic [10:0] bStat [0:DESC-1];
  logic [LW-1:0] bLen [0:DESC-1];
  logic [7:0]  bData [0:DESC-1][0:BUF-1];
  logic [10:0] expStat [0:DESC-1];
  logic [LW-1:0] expLen [0:DESC-1];
  logic [7:0]  expData [0:DESC-1][0:BUF-1];
  int          expPtr;
  logic [1:0]  expEv;

  logic          armEn = 0;
  logic [IW-1:0] armIdx = 0;
  logic [10:0]   armVal = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxbd_ring_engine #(.DESC_CNT(DESC), .LEN_W(LW)) u0 (
    .clk(clk), .rstN(rstN), .baseIdx(baseIdx), .maxLen(maxLen),
    .rxValid(rxValid), .rxSop(rxSop), .rxByte(rxByte), .rxPid(rxPid), .rxEop(rxEop),
    .rxCrcErr(rxCrcErr), .rxNonOct(rxNonOct), .rxOverrun(rxOverrun), .rxStuffErr(rxStuffErr),
    .descRdIdx(descRdIdx), .descRdStat(descRdStat), .descWrEn(descWrEn), .descWrIdx(descWrIdx),
    .descWrStat(descWrStat), .descWrLen(descWrLen), .dataWrEn(dataWrEn), .dataWrIdx(dataWrIdx),
    .dataWrOffset(dataWrOffset), .dataWrByte(dataWrByte), .evClr(evClr), .evMask(evMask),
    .events(events), .irq(irq)
  );

  assign descRdStat = bStat[descRdIdx];

  // Descriptor memory model.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DESC; i++) begin
        bStat[i] <= '0;
        bLen[i]  <= '0;
        for (int j = 0; j < BUF; j++) bData[i][j] <= '0;
      end
    end else if (armEn) begin
      bStat[armIdx] <= armVal;
    end else begin
      if (descWrEn) begin
        bStat[descWrIdx] <= descWrStat;
        bLen[descWrIdx]  <= descWrLen;
      end
      if (dataWrEn && dataWrOffset < BUF) bData[dataWrIdx][dataWrOffset[3:0]] <= dataWrByte;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byteOf(int seed, int k);
    return 8'((seed * 7 + k * 13 + 5) & 255);
  endfunction

  task automatic arm(int idx, logic [10:0] val);
    @(negedge clk);
    armEn = 1; armIdx = IW'(idx); armVal = val;
    expStat[idx] = val;
    @(negedge clk);
    armEn = 0;
  endtask

  // Arm the whole ring empty; ring-end bit on the final descriptor.
  task automatic armRing(bit intr);
    for (int i = BASE; i <= LAST; i++)
      arm(i, {1'b1, (i == LAST), intr, 8'h00});
  endtask

  task automatic closeModel(int p, bit last, bit first, logic [1:0] pid, logic [3:0] fl, int len);
    expStat[p] = {1'b0, expStat[p][9], expStat[p][8], first, last, (first ? pid : 2'b00), fl};
    expLen[p]  = LW'(len);
    if (expStat[p][8]) expEv[0] = 1'b1;
  endtask

  // Reference model of one packet, then drive it.
  task automatic sendPkt(int n, logic [1:0] pid, logic [3:0] fl, int seed);
    int p = expPtr, rem = n, k = 0, chunk, nx, ml = int'(maxLen);
    bit first = 1;
    if (!expStat[p][10]) expEv[1] = 1'b1;
    else begin
      while (rem > 0) begin
        chunk = (rem < ml) ? rem : ml;
        for (int j = 0; j < chunk; j++) begin expData[p][j] = byteOf(seed, k); k++; end
        rem -= chunk;
        nx = expStat[p][9] ? BASE : (p + 1) % DESC;
        if (rem == 0) closeModel(p, 1, first, pid, fl, chunk);
        else if (expStat[nx][10]) closeModel(p, 0, first, pid, 4'h0, chunk);
        else begin closeModel(p, 1, first, pid, 4'h0, chunk); expEv[1] = 1'b1; rem = 0; end
        p = nx; first = 0;
      end
      expPtr = p;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1; rxSop = (i == 0); rxByte = byteOf(seed, i); rxPid = pid;
    end
    @(negedge clk);
    rxValid = 0; rxSop = 0; rxEop = 1;
    {rxNonOct, rxStuffErr, rxCrcErr, rxOverrun} = fl;
    @(negedge clk);
    rxEop = 0; {rxNonOct, rxStuffErr, rxCrcErr, rxOverrun} = 4'h0;
    @(negedge clk);
  endtask

  task automatic checkAll(string req);
    for (int d = 0; d < DESC; d++) begin
      bit ok = (bStat[d] === expStat[d]) && (bLen[d] === expLen[d]);
      check(ok, req, $sformatf("desc %0d status/len", d), int'({bStat[d], bLen[d]}), int'({expStat[d], expLen[d]}));
      ok = 1;
      for (int j = 0; j < BUF; j++) if (bData[d][j] !== expData[d][j]) ok = 0;
      check(ok, req, $sformatf("desc %0d data", d), 0, 1);
    end
    check(events === expEv, "R8 R6 R7", "events", int'(events), int'(expEv));
    check(int'(descRdIdx) == expPtr, "R5", "ring position", int'(descRdIdx), expPtr);
  endtask

  task automatic clrEvents(logic [1:0] m);
    @(negedge clk); evClr = m;
    @(negedge clk); evClr = 0;
    expEv = expEv & ~m;
    @(negedge clk);
    check(events === expEv, "R9", "events after clear", int'(events), int'(expEv));
  endtask

  initial begin
    for (int i = 0; i < DESC; i++) begin
      expStat[i] = '0; expLen[i] = '0;
      for (int j = 0; j < BUF; j++) expData[i][j] = '0;
    end
    expPtr = BASE; expEv = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10
    check(events == 2'b00 && irq == 1'b0, "R10", "events/irq after reset", int'({irq, events}), 0);
    check(!descWrEn && !dataWrEn, "R10", "write strobes after reset", int'({descWrEn, dataWrEn}), 0);
    check(int'(descRdIdx) == BASE, "R10", "ring position after reset", int'(descRdIdx), BASE);

    // Length sweep with maxLen 8: chaining, closing, flags, PID, ring wrap.
    for (int n = 1; n <= 20; n++) begin
      armRing(n % 3 != 0);
      sendPkt(n, 2'(n % 2), 4'(n % 16), n);
      checkAll("R1 R2 R3 R4 R5");
      clrEvents(2'b11);
    end
    // Same sweep with maxLen 4.
    maxLen = 8'd4;
    for (int n = 1; n <= 13; n++) begin
      armRing(n % 2 == 0);
      sendPkt(n, 2'((n + 1) % 2), 4'((n * 5) % 16), n + 40);
      checkAll("R1 R2 R3 R4 R5 R8");
      clrEvents(2'b11);
    end

    // R6: current descriptor owned by software.
    armRing(1);
    arm(expPtr, 11'h100);
    sendPkt(5, 2'b01, 4'h0, 77);
    checkAll("R6");
    check(events[1] === 1'b1, "R6", "busy event on start", int'(events), 2);
    clrEvents(2'b10);

    // R7: only the current descriptor is empty, packet needs three.
    for (int i = BASE; i <= LAST; i++) arm(i, {1'b0, (i == LAST), 1'b1, 8'h00});
    arm(expPtr, {1'b1, (expPtr == LAST), 1'b1, 8'h00});
    sendPkt(10, 2'b00, 4'h2, 91);
    checkAll("R7");
    check(events === 2'b11, "R7", "busy and buffer events mid-packet", int'(events), 3);

    // R9: masking into irq.
    evMask = 2'b00; @(negedge clk);
    check(irq === 1'b0, "R9", "irq masked", int'(irq), 0);
    evMask = 2'b01; @(negedge clk);
    check(irq === 1'b1, "R9", "irq buffer event", int'(irq), 1);
    clrEvents(2'b01);
    check(irq === 1'b0, "R9", "irq after clear of enabled event", int'(irq), 0);
    evMask = 2'b10; @(negedge clk);
    check(irq === 1'b1, "R9", "irq busy event", int'(irq), 1);
    clrEvents(2'b10);
    check(irq === 1'b0, "R9", "irq all clear", int'(irq), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule